// File: doc/BRIEF.md
# I/O MMU Context Register Bank

This block is the software-visible register bank of a small I/O MMU with four translation contexts. Each context has a control word, a table-control word, a bus-control word, two 64-bit translation-table base pointers (each split into low and high halves), two memory-attribute words, a fault status word and a fault address word. All of them sit on a simple 32-bit register bus. The same registers also answer in a second window, 0x800 above the bank base.

A separate translation engine reports faults to the bank. Each report gives the context, a 4-bit fault kind vector, an error code, a level and the faulting virtual address. The bank records the first fault of a burst and accumulates the kinds of later ones. Software clears a fault by writing zeros to the status word. Writing 1 to the flush bit of a context asks the engine for a TLB invalidation. The bit stays set until the engine returns a one-cycle done pulse for that context, so software can poll it. A single interrupt line combines the requests of all contexts.

Each context has two small state machines. The flush machine has the states FL_IDLE and FL_WAIT. A control write with bit 1 set moves it from FL_IDLE to FL_WAIT (transition "start"), and the done pulse moves it back (transition "done"). The fault recorder has the states FR_CLEAR and FR_HELD. A fault report with a nonzero kind moves it from FR_CLEAR to FR_HELD (transition "capture"). In FR_HELD, further reports only add kind bits (transition "merge"). A status write that leaves no kind bit set moves it back to FR_CLEAR (transition "release").

Top module: `xlat_ctx_regbank`

## Requirements
- R1: The bus address decodes as follows. Bit 11 selects the alias window, which maps onto the same registers as the base window. Bits 7:6 give the context and bits 5:0 give the word offset. Any address with a nonzero bit in 10:8, or in bits 1:0, is unmapped: a read of it returns 0 and a write to it changes nothing.
- R2: The configuration words are read/write over all 32 bits. Their offsets are 0x08 (table control), 0x0C (bus control), 0x10/0x14 (table base 0 low/high), 0x18/0x1C (table base 1 low/high), 0x28 and 0x2C (attributes 0 and 1).
- R3: The control word sits at offset 0x00. Only bits 0 (enable), 2 (interrupt enable), 3 (remap enable), 5:4 (select), 16 and 17 store written values. All other bits read 0, except bit 1.
- R4: Bit 1 of the control word is the flush bit. Writing the control word with bit 1 set raises flush_req for that context, and the flush bit reads 1. Both stay set through any later control write until a flush_done pulse arrives for that context, and they read 0 from the next cycle. A flush_done pulse for a context with no pending flush has no effect.
- R5: A fault report with a nonzero kind, arriving in the FR_CLEAR state, loads the status word at offset 0x20 and loads the faulting address into the word at offset 0x24. The status word holds: kind bit 0 (translation) at bit 0, kind bit 1 (permission) at bit 1, kind bit 2 (walk abort) at bit 2, kind bit 3 (multiple hit) at bit 4, the error code at bits 10:8 and the level at bits 13:12.
- R6: A fault report that arrives while status holds any kind bit ORs its kind bits into status. It leaves the error code, the level and the captured address unchanged.
- R7: A write to the status word keeps only those status bits whose written bit is 1. When no kind bit remains after the write, status and the fault address both read 0.
- R8: irq is high exactly when some context has interrupt enable (control bit 2) set and at least one of its kind bits set.
- R9: After reset, every register, flush_req, irq and bus_rvalid read 0.
- R10: A bus read returns its data on bus_rdata with bus_rvalid high in the cycle after the request. bus_rvalid is low after any cycle with no read.
- R11: A fault report whose kind vector is zero has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| flt_valid | input | 1 | Fault report strobe |
| flt_ctx | input | 2 | Context of the fault |
| flt_kind | input | 4 | Fault kinds: translation, permission, abort, multiple hit |
| flt_code | input | 3 | Error code |
| flt_level | input | 2 | Error level |
| flt_vaddr | input | 32 | Faulting virtual address |
| flush_req | output | 4 | Per-context invalidation request |
| flush_done | input | 4 | Per-context invalidation complete pulse |
| irq | output | 1 | Combined interrupt |

## Verification
The bound checker tests on every cycle that a pending flush holds until its done pulse and drops right after it. It also tests that a recorded fault and its address stay put unless software writes the status word, that the address reads zero whenever no fault is held, that irq never rises without a held fault, and that read timing is met. Other behaviour shows only at the bench's register reads. This covers the alias decode, the rejection of unmapped addresses, the write mask of the control word and the exact packing of the status fields. It also covers merging a second fault and the partial and full clears by writing zeros. The bench waits a configurable number of cycles before it sends the done pulse.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int KIND_W = 4;
    localparam int CODE_W = 3;
    localparam int LVL_W  = 2;
    localparam int NUM_CFG = 8;
    localparam int CFG_IW  = $clog2(NUM_CFG);

    localparam logic [5:0] OFS_CTRL  = 6'h00;
    localparam logic [5:0] OFS_TCR   = 6'h08;
    localparam logic [5:0] OFS_BUS   = 6'h0C;
    localparam logic [5:0] OFS_TB0L  = 6'h10;
    localparam logic [5:0] OFS_TB0H  = 6'h14;
    localparam logic [5:0] OFS_TB1L  = 6'h18;
    localparam logic [5:0] OFS_TB1H  = 6'h1C;
    localparam logic [5:0] OFS_STAT  = 6'h20;
    localparam logic [5:0] OFS_FADDR = 6'h24;
    localparam logic [5:0] OFS_ATT0  = 6'h28;
    localparam logic [5:0] OFS_ATT1  = 6'h2C;

    localparam logic [31:0] CTRL_MASK = 32'h0003_003D;
    localparam int CTRL_FLUSH_BIT = 1;
    localparam int CTRL_IEN_BIT   = 2;

    typedef enum logic [2:0] {
        RS_NONE, RS_CTRL, RS_CFG, RS_STAT, RS_FADDR
    } reg_sel_e;

    typedef enum logic {FL_IDLE, FL_WAIT} flush_st_e;
    typedef enum logic {FR_CLEAR, FR_HELD} fault_st_e;
endpackage

// File: rtl/xlat_addr_dec.sv
module xlat_addr_dec import xlat_pkg::*; #(
    parameter int ADDR_W = 12,
    parameter int CTX_W  = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [CTX_W-1:0]  ctx,
    output reg_sel_e          sel,
    output logic [CFG_IW-1:0] cfg_idx
);
    localparam int OFS_W = 6;
    localparam logic [ADDR_W-1:0] ALIAS_OFS = ADDR_W'(1) << (ADDR_W-1);

    logic [ADDR_W-1:0] rel;
    logic              mid_zero;
    logic [OFS_W-1:0]  ofs;

    always_comb begin
        rel      = addr[ADDR_W-1] ? (addr - ALIAS_OFS) : addr;
        mid_zero = (rel[ADDR_W-1:OFS_W+CTX_W] == '0) && (rel[1:0] == 2'b00);
        ofs      = rel[OFS_W-1:0];
        ctx      = rel[OFS_W+CTX_W-1:OFS_W];
        cfg_idx  = '0;
        sel      = RS_NONE;
        if (mid_zero) begin
            unique case (ofs)
                OFS_CTRL:  sel = RS_CTRL;
                OFS_STAT:  sel = RS_STAT;
                OFS_FADDR: sel = RS_FADDR;
                OFS_TCR:   begin sel = RS_CFG; cfg_idx = CFG_IW'(0); end
                OFS_BUS:   begin sel = RS_CFG; cfg_idx = CFG_IW'(1); end
                OFS_TB0L:  begin sel = RS_CFG; cfg_idx = CFG_IW'(2); end
                OFS_TB0H:  begin sel = RS_CFG; cfg_idx = CFG_IW'(3); end
                OFS_TB1L:  begin sel = RS_CFG; cfg_idx = CFG_IW'(4); end
                OFS_TB1H:  begin sel = RS_CFG; cfg_idx = CFG_IW'(5); end
                OFS_ATT0:  begin sel = RS_CFG; cfg_idx = CFG_IW'(6); end
                OFS_ATT1:  begin sel = RS_CFG; cfg_idx = CFG_IW'(7); end
                default:   sel = RS_NONE;
            endcase
        end
    end
endmodule

// File: rtl/xlat_flush_fsm.sv
module xlat_flush_fsm import xlat_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic done,
    output logic pend
);
    flush_st_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= FL_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FL_IDLE: if (start) st_d = FL_WAIT;
            FL_WAIT: if (done)  st_d = FL_IDLE;
            default: st_d = FL_IDLE;
        endcase
    end

    assign pend = (st_q == FL_WAIT);
endmodule

// File: rtl/xlat_fault_rec.sv
module xlat_fault_rec import xlat_pkg::*; #(
    parameter int VA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_wr,
    input  logic [KIND_W-1:0] keep_kind,
    input  logic [CODE_W-1:0] keep_code,
    input  logic [LVL_W-1:0]  keep_lvl,
    input  logic              ev_valid,
    input  logic [KIND_W-1:0] ev_kind,
    input  logic [CODE_W-1:0] ev_code,
    input  logic [LVL_W-1:0]  ev_lvl,
    input  logic [VA_W-1:0]   ev_va,
    output logic [31:0]       status,
    output logic [VA_W-1:0]   faddr,
    output logic              any_fault
);
    fault_st_e         st_q, st_d;
    logic [KIND_W-1:0] kind_q, kind_w, kind_d;
    logic [CODE_W-1:0] code_q, code_w, code_d;
    logic [LVL_W-1:0]  lvl_q, lvl_w, lvl_d;
    logic [VA_W-1:0]   va_q, va_w, va_d;
    logic              held_w, ev_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= FR_CLEAR;
            kind_q <= '0;
            code_q <= '0;
            lvl_q  <= '0;
            va_q   <= '0;
        end else begin
            st_q   <= st_d;
            kind_q <= kind_d;
            code_q <= code_d;
            lvl_q  <= lvl_d;
            va_q   <= va_d;
        end
    end

    always_comb begin
        kind_w = st_wr ? (kind_q & keep_kind) : kind_q;
        code_w = st_wr ? (code_q & keep_code) : code_q;
        lvl_w  = st_wr ? (lvl_q & keep_lvl)   : lvl_q;
        va_w   = va_q;
        held_w = (st_q == FR_HELD) && (kind_w != '0);
        if (!held_w) begin
            code_w = '0;
            lvl_w  = '0;
            va_w   = '0;
        end
        ev_hit = ev_valid && (ev_kind != '0);
        kind_d = kind_w;
        code_d = code_w;
        lvl_d  = lvl_w;
        va_d   = va_w;
        st_d   = held_w ? FR_HELD : FR_CLEAR;
        unique case (st_d)
            FR_CLEAR: if (ev_hit) begin
                kind_d = ev_kind;
                code_d = ev_code;
                lvl_d  = ev_lvl;
                va_d   = ev_va;
                st_d   = FR_HELD;
            end
            FR_HELD: if (ev_hit) kind_d = kind_w | ev_kind;
            default: st_d = FR_CLEAR;
        endcase
    end

    assign status = {18'b0, lvl_q, 1'b0, code_q, 3'b0, kind_q[3], 1'b0, kind_q[2:0]};
    assign faddr = va_q;
    assign any_fault = (kind_q != '0);
endmodule

// File: rtl/xlat_ctx_regbank.sv
module xlat_ctx_regbank import xlat_pkg::*; #(
    parameter int NUM_CTX = 4,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int VA_W    = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic                       bus_rvalid,
    input  logic                       flt_valid,
    input  logic [$clog2(NUM_CTX)-1:0] flt_ctx,
    input  logic [KIND_W-1:0]          flt_kind,
    input  logic [CODE_W-1:0]          flt_code,
    input  logic [LVL_W-1:0]           flt_level,
    input  logic [VA_W-1:0]            flt_vaddr,
    output logic [NUM_CTX-1:0]         flush_req,
    input  logic [NUM_CTX-1:0]         flush_done,
    output logic                       irq
);
    localparam int CTX_W = $clog2(NUM_CTX);

    logic [CTX_W-1:0]  dec_ctx;
    reg_sel_e          dec_sel;
    logic [CFG_IW-1:0] dec_cfg;

    logic [DATA_W-1:0] ctrl_q [NUM_CTX];
    logic [DATA_W-1:0] cfg_q  [NUM_CTX][NUM_CFG];
    logic [31:0]       stat_v [NUM_CTX];
    logic [NUM_CTX-1:0][VA_W-1:0] fa_q;
    logic [NUM_CTX-1:0] flt_any, ien, st_wr_v, fl_start;
    logic               wr_en, rd_en;
    logic [DATA_W-1:0]  rd_mux;

    xlat_addr_dec #(.ADDR_W(ADDR_W), .CTX_W(CTX_W)) u_dec (
        .addr(bus_addr), .ctx(dec_ctx), .sel(dec_sel), .cfg_idx(dec_cfg)
    );

    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && !bus_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CTX; c++) begin
                ctrl_q[c] <= '0;
                for (int r = 0; r < NUM_CFG; r++) cfg_q[c][r] <= '0;
            end
        end else if (wr_en) begin
            if (dec_sel == RS_CTRL) ctrl_q[dec_ctx] <= bus_wdata & DATA_W'(CTRL_MASK);
            if (dec_sel == RS_CFG)  cfg_q[dec_ctx][dec_cfg] <= bus_wdata;
        end
    end

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        assign fl_start[c] = wr_en && (dec_sel == RS_CTRL) && (dec_ctx == CTX_W'(c))
                             && bus_wdata[CTRL_FLUSH_BIT];
        assign st_wr_v[c]  = wr_en && (dec_sel == RS_STAT) && (dec_ctx == CTX_W'(c));
        assign ien[c]      = ctrl_q[c][CTRL_IEN_BIT];

        xlat_flush_fsm u_fl (
            .clk(clk), .rst_n(rst_n), .start(fl_start[c]),
            .done(flush_done[c]), .pend(flush_req[c])
        );

        xlat_fault_rec #(.VA_W(VA_W)) u_fr (
            .clk(clk), .rst_n(rst_n),
            .st_wr(st_wr_v[c]),
            .keep_kind({bus_wdata[4], bus_wdata[2:0]}),
            .keep_code(bus_wdata[10:8]),
            .keep_lvl(bus_wdata[13:12]),
            .ev_valid(flt_valid && (flt_ctx == CTX_W'(c))),
            .ev_kind(flt_kind), .ev_code(flt_code), .ev_lvl(flt_level),
            .ev_va(flt_vaddr),
            .status(stat_v[c]), .faddr(fa_q[c]), .any_fault(flt_any[c])
        );
    end

    always_comb begin
        rd_mux = '0;
        unique case (dec_sel)
            RS_CTRL:  rd_mux = ctrl_q[dec_ctx]
                             | (DATA_W'(flush_req[dec_ctx]) << CTRL_FLUSH_BIT);
            RS_CFG:   rd_mux = cfg_q[dec_ctx][dec_cfg];
            RS_STAT:  rd_mux = DATA_W'(stat_v[dec_ctx]);
            RS_FADDR: rd_mux = DATA_W'(fa_q[dec_ctx]);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= rd_en;
            if (rd_en) bus_rdata <= rd_mux;
        end
    end

    assign irq = |(ien & flt_any);
endmodule

// File: rtl/xlat_ctx_regbank_chk.sv
module xlat_ctx_regbank_chk #(
    parameter int NUM_CTX = 4,
    parameter int VA_W    = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_sel,
    input logic                          bus_wr,
    input logic                          bus_rvalid,
    input logic [NUM_CTX-1:0]            flush_req,
    input logic [NUM_CTX-1:0]            flush_done,
    input logic                          irq,
    input logic [NUM_CTX-1:0]            flt_any,
    input logic [NUM_CTX-1:0]            st_wr_v,
    input logic [NUM_CTX-1:0][VA_W-1:0]  fa_q
);
    p_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> bus_rvalid);
    p_no_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> !bus_rvalid);
    p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flt_any != '0));

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_c
        p_flush_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (flush_req[c] && !flush_done[c]) |=> flush_req[c]);
        p_flush_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (flush_req[c] && flush_done[c]) |=> !flush_req[c]);
        p_addr_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (flt_any[c] && !st_wr_v[c]) |=> $stable(fa_q[c]));
        p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (flt_any[c] && !st_wr_v[c]) |=> flt_any[c]);
        p_addr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !flt_any[c] |-> (fa_q[c] == '0));
    end
endmodule

bind xlat_ctx_regbank xlat_ctx_regbank_chk #(.NUM_CTX(NUM_CTX), .VA_W(VA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rvalid(bus_rvalid), .flush_req(flush_req), .flush_done(flush_done),
    .irq(irq), .flt_any(flt_any), .st_wr_v(st_wr_v), .fa_q(fa_q)
);

// File: tb/xlat_ctx_regbank_bench.sv
module xlat_ctx_regbank_bench;
    localparam int DONE_LAT = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        flt_valid = 1'b0;
    logic [1:0]  flt_ctx = '0;
    logic [3:0]  flt_kind = '0;
    logic [2:0]  flt_code = '0;
    logic [1:0]  flt_level = '0;
    logic [31:0] flt_vaddr = '0;
    logic [3:0]  flush_req;
    logic [3:0]  flush_done = '0;
    logic        irq;

    int total = 0;
    int bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    xlat_ctx_regbank u_xlat_ctx_regbank (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .flt_valid(flt_valid), .flt_ctx(flt_ctx),
        .flt_kind(flt_kind), .flt_code(flt_code), .flt_level(flt_level),
        .flt_vaddr(flt_vaddr), .flush_req(flush_req), .flush_done(flush_done),
        .irq(irq)
    );

    // monitor: pops expected read data as results appear
    always @(negedge clk) begin
        if (bus_rvalid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL unexpected read data %h expected none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    bad++;
                    $display("FAIL %s read actual=%h expected=%h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic fault(input logic [1:0] c, input logic [3:0] k, input logic [2:0] cd,
                         input logic [1:0] lv, input logic [31:0] va);
        @(negedge clk);
        flt_valid = 1'b1; flt_ctx = c; flt_kind = k; flt_code = cd;
        flt_level = lv; flt_vaddr = va;
        @(negedge clk);
        flt_valid = 1'b0;
    endtask

    task automatic pulse_done(input logic [3:0] m);
        @(negedge clk);
        flush_done = m;
        @(negedge clk);
        flush_done = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        chk("R9 irq", {31'b0, irq}, 32'h0);
        chk("R9 flush_req", {28'b0, flush_req}, 32'h0);
        chk("R9 rvalid", {31'b0, bus_rvalid}, 32'h0);
        rd(12'h000, 32'h0, "R9 ctrl0");
        rd(12'h0A0, 32'h0, "R9 stat2");
        rd(12'h0D0, 32'h0, "R9 tb0l3");

        // R2 / R1 config read-write and alias window
        wr(12'h008, 32'hA5A5_1234);
        rd(12'h008, 32'hA5A5_1234, "R2 tcr0");
        wr(12'h8EC, 32'hDEAD_BEEF);
        rd(12'h0EC, 32'hDEAD_BEEF, "R1 alias write att1 ctx3");
        wr(12'h054, 32'h0000_00FF);
        rd(12'h854, 32'h0000_00FF, "R1 alias read tb0h ctx1");
        // R1 unmapped addresses
        wr(12'h108, 32'h0000_0001);
        rd(12'h108, 32'h0, "R1 unmapped read");
        rd(12'h008, 32'hA5A5_1234, "R1 unmapped write ignored");
        wr(12'h00A, 32'h0000_0002);
        rd(12'h008, 32'hA5A5_1234, "R1 misaligned write ignored");

        // R3 control mask
        wr(12'h080, 32'hFFFF_FFFD);
        rd(12'h080, 32'h0003_003D, "R3 ctrl2 mask");
        chk("R3 no flush from masked write", {28'b0, flush_req}, 32'h0);

        // R4 flush handshake
        wr(12'h040, 32'h0000_0002);
        chk("R4 flush_req raised", {28'b0, flush_req}, 32'h2);
        wr(12'h040, 32'h0000_0000);
        rd(12'h040, 32'h0000_0002, "R4 flush bit held after zero write");
        pulse_done(4'b0001);
        chk("R4 stray done ignored", {28'b0, flush_req}, 32'h2);
        for (int i = 0; i < DONE_LAT; i++) begin
            @(negedge clk);
            chk("R4 flush held during latency", {28'b0, flush_req}, 32'h2);
        end
        pulse_done(4'b0010);
        chk("R4 flush cleared by done", {28'b0, flush_req}, 32'h0);
        rd(12'h040, 32'h0, "R4 flush bit reads 0");

        // R5 fault capture, R8 irq
        fault(2'd2, 4'b0001, 3'd1, 2'd2, 32'h1234_5000);
        chk("R8 irq on enabled ctx", {31'b0, irq}, 32'h1);
        rd(12'h0A0, 32'h0000_2101, "R5 stat2 fields");
        rd(12'h0A4, 32'h1234_5000, "R5 faddr2");

        // R6 merge
        fault(2'd2, 4'b1000, 3'd4, 2'd1, 32'hFFFF_0000);
        rd(12'h0A0, 32'h0000_2111, "R6 stat2 merged");
        rd(12'h0A4, 32'h1234_5000, "R6 faddr2 kept");

        // R11 zero-kind report ignored
        fault(2'd0, 4'b0000, 3'd5, 2'd3, 32'h0000_0055);
        rd(12'h020, 32'h0, "R11 stat0 untouched");
        rd(12'h024, 32'h0, "R11 faddr0 untouched");

        // R7 clear by writing zeros
        wr(12'h0A0, 32'hFFFF_FFEF);
        rd(12'h0A0, 32'h0000_2101, "R7 partial clear");
        rd(12'h0A4, 32'h1234_5000, "R7 faddr kept on partial clear");
        chk("R8 irq still high", {31'b0, irq}, 32'h1);
        wr(12'h0A0, 32'h0000_0000);
        rd(12'h0A0, 32'h0, "R7 full clear");
        rd(12'h0A4, 32'h0, "R7 faddr reads 0");
        chk("R8 irq low after clear", {31'b0, irq}, 32'h0);

        // R8 interrupt enable gating
        fault(2'd3, 4'b0010, 3'd0, 2'd0, 32'h0000_4000);
        chk("R8 irq masked ctx3", {31'b0, irq}, 32'h0);
        rd(12'h0E0, 32'h0000_0002, "R5 stat3 perm bit");
        wr(12'h0C0, 32'h0000_0004);
        chk("R8 irq after enable", {31'b0, irq}, 32'h1);
        wr(12'h0C0, 32'h0000_0000);
        chk("R8 irq after disable", {31'b0, irq}, 32'h0);

        repeat (4) @(negedge clk);
        chk("R10 all reads returned", exp_q.size(), 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule